// File: doc/BRIEF.md
# Addressed Serial Stereo Attenuation Receiver

This block accepts 16-bit commands on a three-line serial port made of data, shift clock and latch strobe. It turns them into per-channel attenuation settings for a stereo gain stage. All serial lines are brought into the system clock domain and their edges are detected there. Each rising shift-clock edge moves one data bit into a frame register, most significant bit first. A rising latch edge commits the frame, and only then.

A committed frame takes effect only when its two address bits equal the two strap pins. This lets several receivers share one serial port. A two-bit selector in the frame chooses the channels to update: both, left only, right only, or neither. The low byte is the attenuation code. Codes up to 80 give the attenuation in whole decibels. Every larger code means mute. For each channel the block presents the raw code, a decoded step value and a mute flag, all held in registers.

Top module: `vol_cmd_rx`

## Requirements
- R1: While rst_n is low at a clock edge, both attenuation registers become 0xFF, both step outputs become 80 and both mute flags become 1.
- R2: On each rising ser_clk edge, ser_data is shifted in. The frame is taken most significant bit first, so the first of 16 bits becomes bit 15.
- R3: Shift-clock activity without a rising ser_latch edge leaves every output unchanged.
- R4: When more than 16 bits are shifted before a latch, only the last 16 form the frame.
- R5: A frame is discarded, leaving all outputs unchanged, unless bit 13 equals strap_a1 and bit 12 equals strap_a2.
- R6: Frame bits 15, 14, 11 and 10 have no effect on any output.
- R7: Selector bits 9:8 = 00 load the code in bits 7:0 into both channels.
- R8: Selector 01 loads only the left channel and selector 10 loads only the right channel. The other channel keeps its value.
- R9: Selector 11 changes neither channel.
- R10: For a code from 0 to 80 (0x50), the channel's step output equals the code and its mute flag is 0.
- R11: For a code from 81 to 255, the channel's mute flag is 1 and its step output is 80. The attenuation register still holds the code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_data | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial shift clock, sampled on its rising edge |
| ser_latch | input | 1 | Latch strobe, commits on its rising edge |
| strap_a1 | input | 1 | Address strap compared with frame bit 13 |
| strap_a2 | input | 1 | Address strap compared with frame bit 12 |
| left_att | output | 8 | Left attenuation code |
| right_att | output | 8 | Right attenuation code |
| left_step | output | 7 | Left attenuation step, 0 to 80 |
| right_step | output | 7 | Right attenuation step, 0 to 80 |
| left_mute | output | 1 | Left mute flag |
| right_mute | output | 1 | Right mute flag |

## Verification
On every cycle the assertions check four things. Outputs hold still in any cycle without a detected latch edge. Mismatched addresses and the no-change selector leave both channels alone. A left-only command touches only the left channel. Each channel's step and mute stay consistent with its stored code. Other behaviour can only be shown by the bench's scenarios, because it depends on the bit stream as a whole: the order in which serial bits land in the frame, that the last 16 of an over-long burst win, that the don't-care bits have no effect, and the reset values seen at the ports.

// File: rtl/vol_pkg.sv
// Package: shared constants and types for the serial attenuation receiver.
// Assumes a 16-bit frame with fixed field positions that the decoder relies on.
package vol_pkg;
    localparam int FRAME_W   = 16;
    localparam int CODE_W    = 8;
    localparam int ADDR_HI   = 13;   // compared with strap_a1
    localparam int ADDR_LO   = 12;   // compared with strap_a2
    localparam int SEL_HI    = 9;
    localparam int SEL_LO    = 8;
    localparam int MAX_STEP  = 80;

    typedef enum logic [1:0] {
        SEL_BOTH  = 2'b00,
        SEL_LEFT  = 2'b01,
        SEL_RIGHT = 2'b10,
        SEL_NONE  = 2'b11
    } chan_sel_e;

    typedef struct packed {
        logic [1:0]        addr;
        chan_sel_e         sel;
        logic [CODE_W-1:0] code;
    } cmd_t;
endpackage

// File: rtl/vcr_sync_edge.sv
// Module: two-flop synchroniser with rising-edge detection, one lane per bit.
// Assumes asynchronous inputs that are slow compared with clk.
module vcr_sync_edge #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] level,
    output logic [W-1:0] rise
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    // Purpose: two synchroniser stages plus a delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    genvar b;
    generate
        for (b = 0; b < W; b++) begin : g_lane
            // Purpose: a lane rises when its synchronised level goes from 0 to 1.
            assign rise[b] = sync_q[b] & ~prev_q[b];
        end
    endgenerate

    assign level = sync_q;
endmodule

// File: rtl/vcr_shifter.sv
// Module: frame shift register, MSB first; new bits enter at bit 0.
// Assumes shift_en is a single-cycle pulse per serial clock edge.
module vcr_shifter #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               din,
    output logic [FRAME_W-1:0] frame
);
    logic [FRAME_W-1:0] frame_q;

    // Purpose: shift left on each serial clock edge, keeping the last FRAME_W bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            frame_q <= '0;
        else if (shift_en)
            frame_q <= {frame_q[FRAME_W-2:0], din};
    end

    assign frame = frame_q;
endmodule

// File: rtl/vcr_decode.sv
// Module: combinational command decoder producing per-channel load strobes.
// Assumes frame is stable in the cycle that commit is high.
module vcr_decode
    import vol_pkg::*;
(
    input  logic               commit,
    input  logic [FRAME_W-1:0] frame,
    input  logic               strap_a1,
    input  logic               strap_a2,
    output logic [1:0]         load,      // [0] left, [1] right
    output logic [CODE_W-1:0]  code
);
    cmd_t cmd;
    logic hit;

    // Purpose: pull fields out of the frame, ignoring the don't-care bits.
    always_comb begin
        cmd.addr = {frame[ADDR_HI], frame[ADDR_LO]};
        cmd.sel  = chan_sel_e'(frame[SEL_HI:SEL_LO]);
        cmd.code = frame[CODE_W-1:0];
    end

    // Purpose: the address must match the straps before anything is loaded.
    assign hit = commit && (cmd.addr == {strap_a1, strap_a2});

    // Purpose: map the selector to per-channel load strobes.
    always_comb begin
        load = 2'b00;
        if (hit) begin
            unique case (cmd.sel)
                SEL_BOTH:  load = 2'b11;
                SEL_LEFT:  load = 2'b01;
                SEL_RIGHT: load = 2'b10;
                SEL_NONE:  load = 2'b00;
            endcase
        end
    end

    assign code = cmd.code;
endmodule

// File: rtl/vcr_channel.sv
// Module: one channel's attenuation register with registered step and mute.
// Assumes code values above MAX_STEP mean mute; reset mutes the channel.
module vcr_channel #(
    parameter int CODE_W   = 8,
    parameter int STEP_W   = 7,
    parameter int MAX_STEP = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] att,
    output logic [STEP_W-1:0] step,
    output logic              mute
);
    localparam logic [CODE_W-1:0] LIMIT    = CODE_W'(MAX_STEP);
    localparam logic [STEP_W-1:0] STEP_MAX = STEP_W'(MAX_STEP);

    logic              over;
    logic [STEP_W-1:0] step_next;

    // Purpose: classify the incoming code and saturate the step for mute codes.
    always_comb begin
        over      = code > LIMIT;
        step_next = over ? STEP_MAX : code[STEP_W-1:0];
    end

    // Purpose: hold code, step and mute; update only on a load strobe or reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            att  <= '1;
            step <= STEP_MAX;
            mute <= 1'b1;
        end else if (load) begin
            att  <= code;
            step <= step_next;
            mute <= over;
        end
    end
endmodule

// File: rtl/vol_cmd_rx.sv
// Module: top of the addressed serial stereo attenuation receiver.
// Assumes serial lines toggle slower than a few clk periods per phase.
module vol_cmd_rx
    import vol_pkg::*;
#(
    parameter int STEP_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_data,
    input  logic              ser_clk,
    input  logic              ser_latch,
    input  logic              strap_a1,
    input  logic              strap_a2,
    output logic [CODE_W-1:0] left_att,
    output logic [CODE_W-1:0] right_att,
    output logic [STEP_W-1:0] left_step,
    output logic [STEP_W-1:0] right_step,
    output logic              left_mute,
    output logic              right_mute
);
    localparam int NCH = 2;
    localparam int LANES = 3;   // [0] data, [1] shift clock, [2] latch

    logic [LANES-1:0]   lvl;
    logic [LANES-1:0]   rise;
    logic               shift_rise;
    logic               latch_rise;
    logic [FRAME_W-1:0] frame_q;
    logic [NCH-1:0]     load;
    logic [CODE_W-1:0]  code;
    logic [CODE_W-1:0]  att_q  [NCH];
    logic [STEP_W-1:0]  step_q [NCH];
    logic [NCH-1:0]     mute_q;

    vcr_sync_edge #(.W(LANES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ser_latch, ser_clk, ser_data}),
        .level    (lvl),
        .rise     (rise)
    );

    assign shift_rise = rise[1];
    assign latch_rise = rise[2];

    vcr_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_rise),
        .din      (lvl[0]),
        .frame    (frame_q)
    );

    vcr_decode u_dec (
        .commit   (latch_rise),
        .frame    (frame_q),
        .strap_a1 (strap_a1),
        .strap_a2 (strap_a2),
        .load     (load),
        .code     (code)
    );

    genvar ch;
    generate
        for (ch = 0; ch < NCH; ch++) begin : g_ch
            vcr_channel #(
                .CODE_W   (CODE_W),
                .STEP_W   (STEP_W),
                .MAX_STEP (MAX_STEP)
            ) u_chan (
                .clk   (clk),
                .rst_n (rst_n),
                .load  (load[ch]),
                .code  (code),
                .att   (att_q[ch]),
                .step  (step_q[ch]),
                .mute  (mute_q[ch])
            );
        end
    endgenerate

    assign left_att   = att_q[0];
    assign right_att  = att_q[1];
    assign left_step  = step_q[0];
    assign right_step = step_q[1];
    assign left_mute  = mute_q[0];
    assign right_mute = mute_q[1];
endmodule

// File: rtl/vol_cmd_rx_chk.sv
// Module: assertion checker bound to vol_cmd_rx; observes ports and the
// internal latch-edge pulse and frame register.
module vol_cmd_rx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        latch_rise,
    input logic [15:0] frame_q,
    input logic        strap_a1,
    input logic        strap_a2,
    input logic [7:0]  left_att,
    input logic [7:0]  right_att,
    input logic [6:0]  left_step,
    input logic [6:0]  right_step,
    input logic        left_mute,
    input logic        right_mute
);
    // R3: no latch edge, no output change
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_rise |=> $stable(left_att) && $stable(right_att) &&
                        $stable(left_mute) && $stable(right_mute) &&
                        $stable(left_step) && $stable(right_step));

    // R5: address mismatch discards the frame
    a_r5_addr_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_rise && ({frame_q[13], frame_q[12]} != {strap_a1, strap_a2}))
        |=> $stable(left_att) && $stable(right_att));

    // R8: left-only selector loads left, leaves right
    a_r8_left_only: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_rise && ({frame_q[13], frame_q[12]} == {strap_a1, strap_a2}) &&
         frame_q[9:8] == 2'b01)
        |=> (left_att == $past(frame_q[7:0])) && $stable(right_att));

    // R9: selector 11 changes nothing
    a_r9_sel_none: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_rise && frame_q[9:8] == 2'b11)
        |=> $stable(left_att) && $stable(right_att));

    // R10: in-range code gives step equal to the code, unmuted
    a_r10_step_left: assert property (@(posedge clk) disable iff (!rst_n)
        (left_att <= 8'd80) |-> (!left_mute && left_step == left_att[6:0]));
    a_r10_step_right: assert property (@(posedge clk) disable iff (!rst_n)
        (right_att <= 8'd80) |-> (!right_mute && right_step == right_att[6:0]));

    // R11: out-of-range code mutes with saturated step
    a_r11_mute_left: assert property (@(posedge clk) disable iff (!rst_n)
        (left_att > 8'd80) |-> (left_mute && left_step == 7'd80));
    a_r11_mute_right: assert property (@(posedge clk) disable iff (!rst_n)
        (right_att > 8'd80) |-> (right_mute && right_step == 7'd80));
endmodule

bind vol_cmd_rx vol_cmd_rx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .latch_rise (latch_rise),
    .frame_q    (frame_q),
    .strap_a1   (strap_a1),
    .strap_a2   (strap_a2),
    .left_att   (left_att),
    .right_att  (right_att),
    .left_step  (left_step),
    .right_step (right_step),
    .left_mute  (left_mute),
    .right_mute (right_mute)
);

// File: tb/vol_cmd_rx_test.sv
`timescale 1ns/1ps
module vol_cmd_rx_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_data = 1'b0, ser_clk = 1'b0, ser_latch = 1'b0;
    logic strap_a1 = 1'b1, strap_a2 = 1'b0;   // address 10
    logic [7:0] left_att, right_att;
    logic [6:0] left_step, right_step;
    logic left_mute, right_mute;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    vol_cmd_rx uut (
        .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
        .ser_latch(ser_latch), .strap_a1(strap_a1), .strap_a2(strap_a2),
        .left_att(left_att), .right_att(right_att), .left_step(left_step),
        .right_step(right_step), .left_mute(left_mute), .right_mute(right_mute)
    );

    // {frame, expected left, expected right}; state carries from row to row
    localparam logic [31:0] VEC [10] = '{
        {16'h2000, 8'h00, 8'h00},   // both, 0 dB
        {16'h2114, 8'h14, 8'h00},   // left only
        {16'h2250, 8'h14, 8'h50},   // right only, -80 dB
        {16'h2251, 8'h14, 8'h51},   // right mute code
        {16'h2305, 8'h14, 8'h51},   // selector 11
        {16'h0005, 8'h14, 8'h51},   // address 00 mismatch
        {16'h3007, 8'h14, 8'h51},   // address 11 mismatch
        {16'hEC07, 8'h07, 8'h07},   // don't-care bits set
        {16'h20FF, 8'hFF, 8'hFF},   // both mute
        {16'h2150, 8'h50, 8'hFF}    // left boundary 80
    };

    function automatic string vreq(int i);
        case (i)
            0: return "R7";
            1: return "R8";
            2: return "R8";
            3: return "R11";
            4: return "R9";
            5: return "R5";
            6: return "R5";
            7: return "R6";
            8: return "R11";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = v[i];
            ser_clk  = 1'b0;
            wait_clk(4);
            ser_clk = 1'b1;
            wait_clk(4);
        end
        ser_clk = 1'b0;
        wait_clk(4);
    endtask

    task automatic pulse_latch;
        ser_latch = 1'b1;
        wait_clk(6);
        ser_latch = 1'b0;
        wait_clk(6);
    endtask

    // check code, step and mute of both channels against expected codes
    task automatic chk_both(input string req, input logic [7:0] el, input logic [7:0] er);
        chk({req, " left_att"}, 32'(left_att), 32'(el));
        chk({req, " right_att"}, 32'(right_att), 32'(er));
        chk({req, " R10 R11 left_step"}, 32'(left_step), (el > 8'd80) ? 32'd80 : 32'(el));
        chk({req, " R10 R11 right_step"}, 32'(right_step), (er > 8'd80) ? 32'd80 : 32'(er));
        chk({req, " R10 R11 left_mute"}, 32'(left_mute), 32'(el > 8'd80));
        chk({req, " R10 R11 right_mute"}, 32'(right_mute), 32'(er > 8'd80));
    endtask

    initial begin
        wait_clk(5);
        chk_both("R1 reset", 8'hFF, 8'hFF);
        rst_n = 1'b1;
        wait_clk(3);

        for (int i = 0; i < 10; i++) begin
            send_bits(32'(VEC[i][31:16]), 16);
            pulse_latch();
            chk_both(vreq(i), VEC[i][15:8], VEC[i][7:0]);
        end

        // R3: bits shifted without latch leave outputs as they were
        send_bits(32'h2001, 16);
        chk_both("R3 no latch", 8'h50, 8'hFF);
        // R2: MSB-first order, committed by a latch alone
        pulse_latch();
        chk_both("R2 msb first", 8'h01, 8'h01);

        // R4: 20 bits, leading four are junk (would form 0xF... address 11)
        send_bits(32'hF2133, 20);
        pulse_latch();
        chk_both("R4 last sixteen", 8'h33, 8'h01);

        // R2: asymmetric pattern distinguishes bit order
        send_bits(32'h2242, 16);
        pulse_latch();
        chk_both("R2 order right", 8'h33, 8'h42);

        // R1: reset in mid-run restores mute
        rst_n = 1'b0;
        wait_clk(3);
        chk_both("R1 mid reset", 8'hFF, 8'hFF);
        rst_n = 1'b1;
        wait_clk(3);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule